// File: doc/BRIEF.md
# Indirect Channel Register Access Controller

This block sits between a host register bus and a bank of per-channel setting registers that are not directly mapped. The host picks a target by loading a channel number and an offset into front-end registers, loads a data word when it intends to write, and then issues a command through a control/status register. A sequencer drives one access on a simple back-end port and holds a busy flag until the access is complete. The host polls that flag.

For a read, the back end returns its word a fixed number of cycles after the request strobe. The controller places that word in its data register on the edge that drops busy, so the host reads the result from the data register once it sees busy low. Commands that cannot be served are refused: a command that arrives while busy, a channel number outside the configured count, or both command bits set at once. A refused command produces no back-end traffic and raises a sticky error flag, which the next write to the control/status register clears.

Top module: `chan_indirect_ctrl`

## Requirements
- R1: After reset, every host-visible register reads zero, busy and error are low, and neither back-end strobe is active.
- R2: The host map is channel at word 0x8, control/status at 0xA, offset at 0xB and data at 0xC. Each reads back what was written. All other addresses read zero, and writes to them change nothing.
- R3: Writing 0xA with bit 0 set launches a read. In the cycle after the launch edge, `be_re` is high for exactly one cycle, and `be_chan`/`be_offset` carry the loaded channel and offset.
- R4: Busy (control/status bit 8) reads 1 from the second cycle after the command write. It stays 1 for RD_LAT+1 cycles and then reads 0.
- R5: On a read, the data register is loaded with `be_rdata` from the last busy cycle, on the same edge that busy clears.
- R6: Writing 0xA with bit 1 set launches a write. `be_we` is high for one cycle, and `be_chan`, `be_offset` and `be_wdata` carry the loaded channel, offset and data word. Busy follows the R4 timing.
- R7: The command bits (0xA bits 1:0) read back as written only in the cycle after the control/status write. After that they read 0.
- R8: A command that arrives while busy is set is ignored: it produces no back-end strobe, and the error flag (0xA bit 9) is set.
- R9: A command whose channel is NUM_CH or above sets the error flag. No strobe is produced and busy stays low.
- R10: A command with bits 0 and 1 both set sets the error flag and produces no access.
- R11: Any write to 0xA clears the error flag, unless the command in that write is itself refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | ADDR_W | Host word address |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | HDW | Host write data |
| host_rdata | output | HDW | Host read data for `host_addr` (combinational) |
| be_chan | output | CH_W | Back-end channel of the current access |
| be_offset | output | OFS_W | Back-end register offset of the current access |
| be_re | output | 1 | Back-end read strobe, one cycle |
| be_we | output | 1 | Back-end write strobe, one cycle |
| be_wdata | output | HDW | Back-end write data |
| be_rdata | input | HDW | Back-end read data, valid RD_LAT cycles after `be_re` |

## Verification
The assertions watch the sequencer and register file on every cycle:
- a strobe only ever appears under busy, lasts one cycle, and never asserts both directions together;
- the busy countdown stays within its bound and busy drops when the count expires;
- any strobe carries an in-range channel, and the error flag never rises in a cycle that has a strobe;
- command bits clear themselves.

Only the bench scenarios can show the end-to-end behaviour. These cover the exact cycle in which busy rises and falls, that the captured word is the one the back end returned for the chosen channel and offset, and that data written through the block is later read back. They also show that refused commands leave the back-end contents and strobe counts untouched, and that the error flag clears on the next control/status write.

// File: rtl/cia_pkg.sv
package cia_pkg;

    // Host word addresses; host software depends on these values.
    localparam logic [3:0] A_CHAN = 4'h8;
    localparam logic [3:0] A_CSR  = 4'hA;
    localparam logic [3:0] A_OFS  = 4'hB;
    localparam logic [3:0] A_DATA = 4'hC;

    // Control/status bit positions.
    localparam int B_CMD_RD = 0;
    localparam int B_CMD_WR = 1;
    localparam int B_BUSY   = 8;
    localparam int B_ERR    = 9;

    typedef enum logic [1:0] {
        CMD_NONE = 2'b00,
        CMD_RD   = 2'b01,
        CMD_WR   = 2'b10,
        CMD_BOTH = 2'b11
    } cmd_e;

endpackage

// File: rtl/cia_seq.sv
module cia_seq #(
    parameter int CH_W   = 8,
    parameter int NUM_CH = 4,
    parameter int RD_LAT = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            csr_wr,
    input  logic            cmd_rd,
    input  logic            cmd_wr,
    input  logic [CH_W-1:0] chan,
    output logic            busy,
    output logic            err,
    output logic            launch,
    output logic            strobe_re,
    output logic            strobe_we,
    output logic            capture
);
    localparam int          CNT_W    = (RD_LAT < 1) ? 1 : $clog2(RD_LAT + 1);
    localparam logic [31:0] NUM_CH_U = NUM_CH;

    typedef struct packed {
        logic             busy;
        logic             err;
        logic             is_rd;
        logic             re;
        logic             we;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;
    logic chan_ok;
    logic refuse;

    always_comb begin
        chan_ok = 32'(chan) < NUM_CH_U;
        launch  = (cmd_rd ^ cmd_wr) && !seq_q.busy && chan_ok;
        refuse  = (cmd_rd || cmd_wr) && !launch;
        capture = seq_q.busy && (seq_q.cnt == '0) && seq_q.is_rd;

        seq_d    = seq_q;
        seq_d.re = 1'b0;
        seq_d.we = 1'b0;
        if (seq_q.busy) begin
            if (seq_q.cnt == '0) seq_d.busy = 1'b0;
            else                 seq_d.cnt  = seq_q.cnt - 1'b1;
        end
        if (csr_wr) seq_d.err = 1'b0;
        if (refuse) seq_d.err = 1'b1;
        if (launch) begin
            seq_d.busy  = 1'b1;
            seq_d.cnt   = CNT_W'(RD_LAT);
            seq_d.re    = cmd_rd;
            seq_d.we    = cmd_wr;
            seq_d.is_rd = cmd_rd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy      = seq_q.busy;
    assign err       = seq_q.err;
    assign strobe_re = seq_q.re;
    assign strobe_we = seq_q.we;

    assert_strobe_under_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.re || seq_q.we) |-> seq_q.busy);
    assert_single_direction_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(seq_q.re && seq_q.we));
    assert_strobe_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.re || seq_q.we) |=> !(seq_q.re || seq_q.we));
    assert_busy_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.busy && seq_q.cnt == '0) |=> !seq_q.busy);
    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.busy |-> (32'(seq_q.cnt) <= 32'(RD_LAT)));
    assert_error_no_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_q.err) |-> !(seq_q.re || seq_q.we));

endmodule

// File: rtl/cia_readmux.sv
module cia_readmux #(
    parameter int ADDR_W = 4,
    parameter int CH_W   = 8,
    parameter int OFS_W  = 8,
    parameter int HDW    = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CH_W-1:0]   chan,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [HDW-1:0]    data,
    input  logic [1:0]        cmd,
    input  logic              busy,
    input  logic              err,
    output logic [HDW-1:0]    rdata
);
    import cia_pkg::*;

    logic [HDW-1:0] csr_val;

    always_comb begin
        csr_val           = '0;
        csr_val[B_CMD_RD] = cmd[0];
        csr_val[B_CMD_WR] = cmd[1];
        csr_val[B_BUSY]   = busy;
        csr_val[B_ERR]    = err;
        unique case (addr)
            ADDR_W'(A_CHAN): rdata = HDW'(chan);
            ADDR_W'(A_CSR):  rdata = csr_val;
            ADDR_W'(A_OFS):  rdata = HDW'(ofs);
            ADDR_W'(A_DATA): rdata = data;
            default:         rdata = '0;
        endcase
    end

endmodule

// File: rtl/chan_indirect_ctrl.sv
module chan_indirect_ctrl #(
    parameter int ADDR_W = 4,
    parameter int CH_W   = 8,
    parameter int NUM_CH = 4,
    parameter int OFS_W  = 8,
    parameter int HDW    = 32,
    parameter int RD_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic [HDW-1:0]    host_wdata,
    output logic [HDW-1:0]    host_rdata,
    output logic [CH_W-1:0]   be_chan,
    output logic [OFS_W-1:0]  be_offset,
    output logic              be_re,
    output logic              be_we,
    output logic [HDW-1:0]    be_wdata,
    input  logic [HDW-1:0]    be_rdata
);
    import cia_pkg::*;

    localparam logic [31:0] NUM_CH_U = NUM_CH;

    typedef struct packed {
        logic [CH_W-1:0]  chan;
        logic [OFS_W-1:0] ofs;
        logic [HDW-1:0]   data;
        logic [1:0]       cmd;
        logic [CH_W-1:0]  op_chan;
        logic [OFS_W-1:0] op_ofs;
        logic [HDW-1:0]   op_data;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  csr_wr, busy, err, launch, capture;
    logic  unused_wdata_bits;

    assign csr_wr            = host_wr && (host_addr == ADDR_W'(A_CSR));
    assign unused_wdata_bits = ^host_wdata;

    cia_seq #(.CH_W(CH_W), .NUM_CH(NUM_CH), .RD_LAT(RD_LAT)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .csr_wr   (csr_wr),
        .cmd_rd   (regs_q.cmd[0]),
        .cmd_wr   (regs_q.cmd[1]),
        .chan     (regs_q.chan),
        .busy     (busy),
        .err      (err),
        .launch   (launch),
        .strobe_re(be_re),
        .strobe_we(be_we),
        .capture  (capture)
    );

    always_comb begin
        regs_d     = regs_q;
        regs_d.cmd = CMD_NONE;
        if (host_wr) begin
            unique case (host_addr)
                ADDR_W'(A_CHAN): regs_d.chan = host_wdata[CH_W-1:0];
                ADDR_W'(A_OFS):  regs_d.ofs  = host_wdata[OFS_W-1:0];
                ADDR_W'(A_DATA): regs_d.data = host_wdata;
                ADDR_W'(A_CSR):  regs_d.cmd  = {host_wdata[B_CMD_WR], host_wdata[B_CMD_RD]};
                default: ;
            endcase
        end
        if (launch) begin
            regs_d.op_chan = regs_q.chan;
            regs_d.op_ofs  = regs_q.ofs;
            regs_d.op_data = regs_q.data;
        end
        if (capture) regs_d.data = be_rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign be_chan   = regs_q.op_chan;
    assign be_offset = regs_q.op_ofs;
    assign be_wdata  = regs_q.op_data;

    cia_readmux #(.ADDR_W(ADDR_W), .CH_W(CH_W), .OFS_W(OFS_W), .HDW(HDW)) u_rmux (
        .addr (host_addr),
        .chan (regs_q.chan),
        .ofs  (regs_q.ofs),
        .data (regs_q.data),
        .cmd  (regs_q.cmd),
        .busy (busy),
        .err  (err),
        .rdata(host_rdata)
    );

    assert_cmd_self_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((regs_q.cmd != 2'b00) && !csr_wr) |=> (regs_q.cmd == 2'b00));
    assert_access_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (be_re || be_we) |-> (32'(be_chan) < NUM_CH_U));
    assert_capture_ends_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> !busy);

endmodule

// File: tb/chan_indirect_ctrl_test.sv
module chan_indirect_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int RD_LAT     = 2;
    localparam int NUM_CH     = 4;
    localparam int WATCHDOG   = 50000;
    localparam int N_VEC      = 8;

    localparam logic [3:0] AD_CHAN = 4'h8;
    localparam logic [3:0] AD_CSR  = 4'hA;
    localparam logic [3:0] AD_OFS  = 4'hB;
    localparam logic [3:0] AD_DATA = 4'hC;

    typedef struct packed {
        logic        is_wr;
        logic [7:0]  ch;
        logic [7:0]  ofs;
        logic [31:0] data;
    } vec_t;

    localparam vec_t VEC [N_VEC] = '{
        '{1'b1, 8'd0, 8'h01, 32'h1111_0001},
        '{1'b1, 8'd3, 8'h7F, 32'hCAFE_0003},
        '{1'b0, 8'd0, 8'h01, 32'h0},
        '{1'b0, 8'd3, 8'h7F, 32'h0},
        '{1'b0, 8'd2, 8'h05, 32'h0},
        '{1'b1, 8'd2, 8'h05, 32'h0000_0000},
        '{1'b0, 8'd2, 8'h05, 32'h0},
        '{1'b0, 8'd1, 8'hFF, 32'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [7:0]  be_chan;
    logic [7:0]  be_offset;
    logic        be_re, be_we;
    logic [31:0] be_wdata;
    logic [31:0] be_rdata;

    int n_chk = 0;
    int n_fail = 0;
    int re_cnt = 0;
    int we_cnt = 0;
    bit done = 1'b0;

    logic [31:0] be_mem  [NUM_CH][256];
    logic [31:0] exp_mem [NUM_CH][256];
    logic [31:0] pipe [RD_LAT];

    always #(CLK_PERIOD/2) clk = ~clk;

    chan_indirect_ctrl #(.NUM_CH(NUM_CH), .RD_LAT(RD_LAT)) uut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .be_chan(be_chan),
        .be_offset(be_offset), .be_re(be_re), .be_we(be_we),
        .be_wdata(be_wdata), .be_rdata(be_rdata)
    );

    function automatic logic [31:0] pat(int ch, int ofs);
        return {8'hA5, 8'(ch), 8'(ofs), 8'h3C};
    endfunction

    // Back-end model: fixed read latency, writes on the strobe edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CH; c++)
                for (int o = 0; o < 256; o++) be_mem[c][o] <= pat(c, o);
        end else begin
            if (be_we) be_mem[be_chan[1:0]][be_offset] <= be_wdata;
            if (be_re) re_cnt <= re_cnt + 1;
            if (be_we) we_cnt <= we_cnt + 1;
        end
        pipe[0] <= be_re ? be_mem[be_chan[1:0]][be_offset] : 32'hDEAD_BEEF;
        for (int k = 1; k < RD_LAT; k++) pipe[k] <= pipe[k-1];
    end
    assign be_rdata = pipe[RD_LAT-1];

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_write(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_peek(logic [3:0] a, output logic [31:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            host_peek(AD_CSR, v);
            if (!v[8]) break;
        end
    endtask

    task automatic print_summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R4 watchdog actual=running expected=finished");
            print_summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int re0, we0;
        for (int c = 0; c < NUM_CH; c++)
            for (int o = 0; o < 256; o++) exp_mem[c][o] = pat(c, o);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        host_peek(AD_CHAN, v); check("R1 chan reg", v, 0);
        host_peek(AD_CSR,  v); check("R1 csr reg",  v, 0);
        host_peek(AD_OFS,  v); check("R1 ofs reg",  v, 0);
        host_peek(AD_DATA, v); check("R1 data reg", v, 0);
        check("R1 strobes", {30'd0, be_re, be_we}, 0);

        // R2: map readback and unmapped addresses
        host_write(AD_CHAN, 32'h0000_0002);
        host_write(AD_OFS,  32'h0000_0033);
        host_write(AD_DATA, 32'h1234_5678);
        host_write(4'h9, 32'hFFFF_FFFF);
        host_write(4'h0, 32'hFFFF_FFFF);
        host_peek(AD_CHAN, v); check("R2 chan readback", v, 32'h2);
        host_peek(AD_OFS,  v); check("R2 ofs readback",  v, 32'h33);
        host_peek(AD_DATA, v); check("R2 data readback", v, 32'h1234_5678);
        host_peek(4'h9, v);    check("R2 unmapped 0x9",  v, 0);
        host_peek(4'h0, v);    check("R2 unmapped 0x0",  v, 0);

        // R3 R4 R5 R7: cycle-exact read
        host_write(AD_CHAN, 32'd1);
        host_write(AD_OFS,  32'h20);
        host_write(AD_CSR,  32'h1);
        host_peek(AD_CSR, v);
        check("R7 cmd bit visible", {31'd0, v[0]}, 1);
        check("R4 busy not yet",    {31'd0, v[8]}, 0);
        @(negedge clk);
        host_peek(AD_CSR, v);
        check("R3 be_re pulse",  {31'd0, be_re}, 1);
        check("R3 be_chan",      {24'd0, be_chan}, 1);
        check("R3 be_offset",    {24'd0, be_offset}, 32'h20);
        check("R4 busy set",     {31'd0, v[8]}, 1);
        check("R7 cmd cleared",  {31'd0, v[0]}, 0);
        for (int k = 2; k <= RD_LAT + 1; k++) begin
            @(negedge clk);
            host_peek(AD_CSR, v);
            check("R3 be_re single", {31'd0, be_re}, 0);
            check("R4 busy held",    {31'd0, v[8]}, 1);
        end
        @(negedge clk);
        host_peek(AD_CSR, v);
        check("R4 busy cleared", {31'd0, v[8]}, 0);
        host_peek(AD_DATA, v);
        check("R5 captured data", v, pat(1, 8'h20));

        // R3 R5 R6: vector table
        for (int i = 0; i < N_VEC; i++) begin
            host_write(AD_CHAN, 32'(VEC[i].ch));
            host_write(AD_OFS,  32'(VEC[i].ofs));
            if (VEC[i].is_wr) begin
                host_write(AD_DATA, VEC[i].data);
                host_write(AD_CSR, 32'h2);
                exp_mem[VEC[i].ch[1:0]][VEC[i].ofs] = VEC[i].data;
                wait_idle();
                host_peek(AD_CSR, v);
                check("R6 write done no error", {30'd0, v[9], v[8]}, 0);
            end else begin
                host_write(AD_CSR, 32'h1);
                wait_idle();
                host_peek(AD_DATA, v);
                check("R5 table read data", v, exp_mem[VEC[i].ch[1:0]][VEC[i].ofs]);
            end
        end

        // R8: command while busy is ignored
        host_write(AD_CHAN, 32'd2);
        host_write(AD_OFS,  32'h05);
        we0 = we_cnt;
        host_write(AD_CSR, 32'h1);
        host_write(AD_CSR, 32'h2);
        wait_idle();
        repeat (2) @(negedge clk);
        host_peek(AD_CSR, v);
        check("R8 error set", {31'd0, v[9]}, 1);
        check("R8 no write strobe", 32'(we_cnt), 32'(we0));
        host_peek(AD_DATA, v);
        check("R8 first read intact", v, exp_mem[2][5]);

        // R11: csr write clears error
        host_write(AD_CSR, 32'h0);
        host_peek(AD_CSR, v);
        check("R11 error cleared", {31'd0, v[9]}, 0);

        // R9: channel out of range
        re0 = re_cnt;
        host_write(AD_CHAN, 32'(NUM_CH));
        host_write(AD_CSR, 32'h1);
        repeat (RD_LAT + 3) @(negedge clk);
        host_peek(AD_CSR, v);
        check("R9 error set",   {31'd0, v[9]}, 1);
        check("R9 busy low",    {31'd0, v[8]}, 0);
        check("R9 no strobe",   32'(re_cnt), 32'(re0));
        host_write(AD_CSR, 32'h0);

        // R10: both command bits
        re0 = re_cnt; we0 = we_cnt;
        host_write(AD_CHAN, 32'd0);
        host_write(AD_CSR, 32'h3);
        repeat (RD_LAT + 3) @(negedge clk);
        host_peek(AD_CSR, v);
        check("R10 error set", {31'd0, v[9]}, 1);
        check("R10 no access", 32'(re_cnt + we_cnt), 32'(re0 + we0));
        host_write(AD_CSR, 32'h0);
        host_peek(AD_CSR, v);
        check("R11 cleared again", {31'd0, v[9]}, 0);

        done = 1'b1;
        print_summary();
        $finish;
    end

endmodule